// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Bank

This block gathers a vector of level-sensitive interrupt request lines and steers each one to one of two destinations: the normal request path, or a fast request path. Each source's request is the OR of its hardware level, which is registered once per clock, and a software-forced request bit. Normal-path requests are gated by a per-source enable. The gated vector goes to a downstream priority engine. Fast-path requests ignore the enable and are merged into one fast request line.

Software reaches the block through a simple word-wide register bus. There is a write strobe, a byte address whose two low bits are ignored, and write data. Read data is a combinational function of the address. Reading has no side effects. Enables and software requests each have one write-one-to-set offset and one write-one-to-clear offset, so single bits change without a read-modify-write. The routing word is written whole.

Top module: `irq_route_bank`

## Requirements
- R1: The raw request word, read at byte offset 0x08, equals the sampled hardware levels ORed with the software request word.
- R2: The normal-path status, read at offset 0x00 and driven on `irq_vec`, equals raw AND enable AND NOT route.
- R3: The fast-path status, read at offset 0x04, equals raw AND route. The enable word has no effect on it.
- R4: `fiq_out` is high exactly when at least one fast-path status bit is set.
- R5: Writing to offset 0x10 ORs the data into the enable word. Writing to offset 0x14 clears the enable bits where the data is 1. Offset 0x10 reads back the enable word.
- R6: Writing to offset 0x18 ORs the data into the software request word. Writing to offset 0x1C clears the bits where the data is 1. Offset 0x18 reads back the software request word.
- R7: A write to offset 0x0C loads the route word directly, where bit value 1 means the fast path. The same offset reads it back.
- R8: Writes to the status offsets 0x00, 0x04 and 0x08 change no register.
- R9: A write to offset 0x20 stores only data bit 0 into the guard bit. Reading offset 0x20 returns that bit in bit 0 and zeros above it.
- R10: Reset clears the enable, route and software request words and the guard bit.
- R11: Hardware levels pass through one sampling register. A level change appears in the status words one clock edge later, and a level that drops is not held.
- R12: Address bits 1:0 are ignored. Reads of offsets 0x14, 0x1C and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | N_SRC | Hardware request levels, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data for `bus_addr`, combinational |
| irq_vec | output | N_SRC | Enabled normal-path request vector |
| fiq_out | output | 1 | Fast-path request line |

## Verification
The assertions check the following on every cycle:
- Each set, clear and load write leaves the targeted bits in the required state on the next cycle.
- Status-offset writes leave every register untouched.
- A register is never nonzero right after reset.
- `irq_vec` never carries a source whose enable is clear.
- `fiq_out` never rises while no source is routed to the fast path.

Only the bench's scenarios can show the full arithmetic of the status words against a reference model, including:
- The one-cycle sampling latency and release of dropped hardware levels.
- Read-back of every offset.
- The guard bit's masking to bit 0.
- Zero reads at unmapped and clear-only offsets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Word indexes (byte offset / 4) of the register bank
  localparam int unsigned IDX_IRQ_STAT = 0;
  localparam int unsigned IDX_FIQ_STAT = 1;
  localparam int unsigned IDX_RAW      = 2;
  localparam int unsigned IDX_ROUTE    = 3;
  localparam int unsigned IDX_EN_SET   = 4;
  localparam int unsigned IDX_EN_CLR   = 5;
  localparam int unsigned IDX_SW_SET   = 6;
  localparam int unsigned IDX_SW_CLR   = 7;
  localparam int unsigned IDX_GUARD    = 8;

  // One-hot register select produced by the address decoder
  typedef struct packed {
    logic irq_stat;
    logic fiq_stat;
    logic raw;
    logic route;
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic guard;
  } reg_hit_t;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  localparam int WIDX = ADDR_W - 2;

  logic [WIDX-1:0] widx;
  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    hit = '0;
    case (widx)
      WIDX'(IDX_IRQ_STAT): hit.irq_stat = 1'b1;
      WIDX'(IDX_FIQ_STAT): hit.fiq_stat = 1'b1;
      WIDX'(IDX_RAW):      hit.raw      = 1'b1;
      WIDX'(IDX_ROUTE):    hit.route    = 1'b1;
      WIDX'(IDX_EN_SET):   hit.en_set   = 1'b1;
      WIDX'(IDX_EN_CLR):   hit.en_clr   = 1'b1;
      WIDX'(IDX_SW_SET):   hit.sw_set   = 1'b1;
      WIDX'(IDX_SW_CLR):   hit.sw_clr   = 1'b1;
      WIDX'(IDX_GUARD):    hit.guard    = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] lvl_i,
  output logic [N_SRC-1:0] lvl_q
);
  // Level sampling only: a dropped level is released on the next edge (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_hit_t         hit,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] route_q,
  output logic [N_SRC-1:0] sw_q,
  output logic             guard_q
);
  logic [N_SRC-1:0] en_d, route_d, sw_d;
  logic             guard_d;
  logic             en_ce, route_ce, sw_ce, guard_ce;

  // Next state
  always_comb begin
    en_ce    = wr_en & (hit.en_set | hit.en_clr);
    route_ce = wr_en & hit.route;
    sw_ce    = wr_en & (hit.sw_set | hit.sw_clr);
    guard_ce = wr_en & hit.guard;

    en_d = hit.en_set ? (en_q | wdata) : (en_q & ~wdata);
    sw_d = hit.sw_set ? (sw_q | wdata) : (sw_q & ~wdata);
    route_d = wdata;
    guard_d = wdata[0];
  end

  // State registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      sw_q    <= '0;
      guard_q <= 1'b0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (route_ce) route_q <= route_d;
      if (sw_ce)    sw_q    <= sw_d;
      if (guard_ce) guard_q <= guard_d;
    end
  end

  a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.en_set) |=> ((en_q & $past(wdata)) == $past(wdata)));

  a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.en_clr) |=> ((en_q & $past(wdata)) == '0));

  a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.sw_set) |=> ((sw_q & $past(wdata)) == $past(wdata)));

  a_r6_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.sw_clr) |=> ((sw_q & $past(wdata)) == '0));

  a_r7_route_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.route) |=> (route_q == $past(wdata)));

  a_r9_guard_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.guard) |=> (guard_q == $past(wdata[0])));

  a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (hit.irq_stat || hit.fiq_stat || hit.raw)) |=>
      ($stable(en_q) && $stable(route_q) && $stable(sw_q) && $stable(guard_q)));

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && route_q == '0 && sw_q == '0 && !guard_q));
endmodule

// File: rtl/irq_route_logic.sv
module irq_route_logic
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  reg_hit_t         hit,
  input  logic [N_SRC-1:0] lvl_q,
  input  logic [N_SRC-1:0] en_q,
  input  logic [N_SRC-1:0] route_q,
  input  logic [N_SRC-1:0] sw_q,
  input  logic             guard_q,
  output logic [N_SRC-1:0] irq_vec,
  output logic             fiq_out,
  output logic [N_SRC-1:0] rdata
);
  logic [N_SRC-1:0] raw_w, irq_w, fiq_w;

  always_comb begin
    raw_w   = lvl_q | sw_q;
    irq_w   = raw_w & en_q & ~route_q;
    fiq_w   = raw_w & route_q;
    irq_vec = irq_w;
    fiq_out = |fiq_w;
  end

  // Side-effect free read mux; clear-only and unmapped offsets read zero
  always_comb begin
    rdata = '0;
    if (hit.irq_stat) rdata = irq_w;
    if (hit.fiq_stat) rdata = fiq_w;
    if (hit.raw)      rdata = raw_w;
    if (hit.route)    rdata = route_q;
    if (hit.en_set)   rdata = en_q;
    if (hit.sw_set)   rdata = sw_q;
    if (hit.guard)    rdata = N_SRC'(guard_q);
  end
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic [N_SRC-1:0]  irq_vec,
  output logic              fiq_out
);
  reg_hit_t         hit;
  logic [N_SRC-1:0] lvl_q, en_q, route_q, sw_q;
  logic             guard_q;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  irq_in_sync #(.N_SRC(N_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (src_lvl),
    .lvl_q (lvl_q)
  );

  irq_ctrl_regs #(.N_SRC(N_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .hit     (hit),
    .wdata   (bus_wdata),
    .en_q    (en_q),
    .route_q (route_q),
    .sw_q    (sw_q),
    .guard_q (guard_q)
  );

  irq_route_logic #(.N_SRC(N_SRC)) u_logic (
    .hit     (hit),
    .lvl_q   (lvl_q),
    .en_q    (en_q),
    .route_q (route_q),
    .sw_q    (sw_q),
    .guard_q (guard_q),
    .irq_vec (irq_vec),
    .fiq_out (fiq_out),
    .rdata   (bus_rdata)
  );

  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_vec & ~en_q) == '0));

  a_r4_fiq_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> (route_q != '0));

  a_r3_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_vec & route_q) == '0));
endmodule

// File: tb/tb_irq_route_bank.sv
module tb_irq_route_bank;
  localparam int N  = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_lvl;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata, bus_rdata, irq_vec;
  logic          fiq_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [N-1:0] m_en, m_route, m_sw, m_lvl;
  logic         m_guard;

  irq_route_bank #(.N_SRC(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_vec(irq_vec), .fiq_out(fiq_out)
  );

  always #5 clk = ~clk;

  function automatic logic [N-1:0] exp_rd(int idx);
    logic [N-1:0] raw;
    raw = m_lvl | m_sw;
    case (idx)
      0: return raw & m_en & ~m_route;
      1: return raw & m_route;
      2: return raw;
      3: return m_route;
      4: return m_en;
      6: return m_sw;
      8: return N'(m_guard);
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(int idx, logic [N-1:0] d);
    case (idx)
      3: m_route = d;
      4: m_en    = m_en | d;
      5: m_en    = m_en & ~d;
      6: m_sw    = m_sw | d;
      7: m_sw    = m_sw & ~d;
      8: m_guard = d[0];
      default: ;
    endcase
  endtask

  task automatic do_write(logic [AW-1:0] addr, logic [N-1:0] d, logic [N-1:0] lvl);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr; bus_wdata = d; src_lvl = lvl;
    @(posedge clk);
    model_write(int'(addr[AW-1:2]), d);
    m_lvl = lvl;
  endtask

  task automatic do_read(int idx, string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = AW'(idx * 4);
    #1;
    check(tag, bus_rdata, exp_rd(idx));
    check({tag, " R2 irq_vec"}, irq_vec, exp_rd(0));
    check({tag, " R4 fiq_out"}, N'(fiq_out), N'(|exp_rd(1)));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; src_lvl = '0;
    m_en = '0; m_route = '0; m_sw = '0; m_lvl = '0; m_guard = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_lvl = '0;
    m_en = '0; m_route = '0; m_sw = '0; m_lvl = '0; m_guard = 1'b0;
    repeat (3) @(posedge clk);
    do_reset();

    // R10: reset state of every register
    do_read(3, "R10 route");
    do_read(4, "R10 enable");
    do_read(6, "R10 soft");
    do_read(8, "R10 guard");
    do_read(2, "R1 raw idle");

    // R5: enable set / clear
    do_write(12'h010, 32'hA5A5_00FF, '0);
    do_read(4, "R5 enable set");
    do_write(12'h014, 32'h0000_FFFF, '0);
    do_read(4, "R5 enable clear");

    // R6: software requests set / clear, visible in raw and status
    do_write(12'h018, 32'h8000_0101, '0);
    do_read(6, "R6 soft set");
    do_read(0, "R2 status from soft");
    do_write(12'h01C, 32'h0000_0100, '0);
    do_read(6, "R6 soft clear");

    // R7 and R3: route word, enable does not gate the fast path
    do_write(12'h014, 32'hFFFF_FFFF, '0);
    do_write(12'h00C, 32'h0000_00F0, 32'h0000_0010);
    do_read(3, "R7 route load");
    do_read(1, "R3 fast status with enables off");
    do_write(12'h00C, 32'h0000_0000, 32'h0000_0010);
    do_read(1, "R3 fast status route cleared");

    // R9: only bit 0 kept
    do_write(12'h020, 32'hFFFF_FFFE, '0);
    do_read(8, "R9 guard even data");
    do_write(12'h020, 32'h0000_0003, '0);
    do_read(8, "R9 guard odd data");

    // R8: writes to status offsets change nothing
    do_write(12'h000, 32'hFFFF_FFFF, '0);
    do_write(12'h004, 32'hFFFF_FFFF, '0);
    do_write(12'h008, 32'hFFFF_FFFF, '0);
    do_read(4, "R8 enable kept");
    do_read(3, "R8 route kept");
    do_read(6, "R8 soft kept");
    do_read(8, "R8 guard kept");

    // R12: low address bits ignored, clear-only and unmapped offsets read zero
    do_write(12'h013, 32'h0000_0006, '0);
    do_read(4, "R12 low bits ignored on write");
    do_read(5, "R12 enable-clear reads zero");
    do_read(7, "R12 soft-clear reads zero");
    do_read(9, "R12 unmapped reads zero");
    @(negedge clk); bus_wr = 1'b0; bus_addr = 12'h012; #1;
    check("R12 low bits ignored on read", bus_rdata, m_en);

    // R11: one-edge latency and no latching of a dropped level
    do_write(12'h010, 32'hFFFF_FFFF, '0);
    do_write(12'h01C, 32'hFFFF_FFFF, '0);
    @(negedge clk); bus_wr = 1'b0; bus_addr = 12'h008; src_lvl = 32'h0000_0C00; #1;
    check("R11 level not visible before edge", bus_rdata, 32'h0);
    @(posedge clk); m_lvl = src_lvl;
    do_read(2, "R11 level visible after edge");
    @(negedge clk); src_lvl = '0;
    @(posedge clk); m_lvl = '0;
    do_read(2, "R11 dropped level released");
    do_read(0, "R2 status after drop");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int idx;
      logic [N-1:0] d, lvl;
      idx = int'($urandom % 11);
      d   = ($urandom % 4 == 0) ? (N'(1) << ($urandom % N)) : N'($urandom);
      lvl = ($urandom % 3 == 0) ? '0 : N'($urandom);
      if ($urandom % 4 != 0)
        do_write(AW'(idx * 4 + int'($urandom % 4)), d, lvl);
      else begin
        @(negedge clk); bus_wr = 1'b0; src_lvl = lvl;
        @(posedge clk); m_lvl = lvl;
      end
      case (int'($urandom % 4))
        0: do_read(0, "R2 random irq status");
        1: do_read(1, "R3 random fiq status");
        2: do_read(2, "R1 random raw");
        default: do_read(int'($urandom % 11), "R12 random readback");
      endcase
    end

    // R10: reset in the middle of activity
    do_write(12'h00C, 32'h1234_5678, 32'hFFFF_FFFF);
    do_reset();
    do_read(3, "R10 route after late reset");
    do_read(4, "R10 enable after late reset");
    do_read(6, "R10 soft after late reset");
    do_read(8, "R10 guard after late reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule